// File: doc/BRIEF.md
# Hint-Override Branch Direction Predictor

This block guesses the direction of a conditional branch so that the fetch unit can choose which instruction stream to prefetch. Each branch carries a single static hint bit, chosen by the compiler, that names the direction it expects. The block does not learn taken or not-taken directly. For each branch it learns whether that hint has been agreeing with the real outcome. It returns the hint when the hint has been reliable and the inverse of the hint when the hint has been mostly wrong.

Learning is held in a small untagged table of 2-bit saturating "agreement" counters, indexed by the low word-address bits of the branch. A lookup request (address and hint) flows in on a valid/ready channel. Its direction comes back one cycle later on a second valid/ready channel. The response register holds its value while the consumer stalls. A request is accepted only when the response register is empty or is being drained in the same cycle. Resolved branches return on a training channel that never applies back-pressure.

Top module: `hint_override_bpred`

## Requirements
- R1: After reset every counter is in the strong-agree state (code 0), so each prediction equals the request's hint until training has happened.
- R2: The predicted direction is the request hint XOR the disagreement flag. The flag is set when the indexed counter is in code 2 (weak disagree) or code 3 (strong disagree).
- R3: A training event whose hint differs from its outcome moves the indexed counter one step toward code 3 and saturates there. From strong agree, two such events are needed before the prediction inverts.
- R4: A training event whose hint equals its outcome moves the indexed counter one step toward code 0 and saturates there.
- R5: The table index is address bits [IDX_LSB +: log2(ENTRIES)] (bits 7:2 by default). Addresses that differ only outside those bits share one counter, and the other bits have no effect.
- R6: When a lookup and a training event hit the same entry in the same cycle, the lookup uses the counter value from before the training event.
- R7: A request accepted at a clock edge shows resp_valid high after that edge with its direction. While resp_valid is high and resp_ready is low, resp_valid and resp_taken hold their values.
- R8: req_ready is high exactly when the response register is empty or resp_ready is high.
- R9: upd_ready is always high after reset. When upd_valid is low, the training inputs change no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request can be accepted |
| req_addr | input | ADDR_W | Branch instruction address for the lookup |
| req_hint | input | 1 | Compiler hint, 1 = taken |
| resp_valid | output | 1 | Predicted direction available |
| resp_ready | input | 1 | Consumer takes the prediction |
| resp_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | Training event present |
| upd_ready | output | 1 | Training event accepted (always high) |
| upd_addr | input | ADDR_W | Address of the resolved branch |
| upd_hint | input | 1 | Hint the resolved branch carried |
| upd_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
A wrong counter does not show at the ports until a later lookup of the same index. Hysteresis can hide it further: a counter that is off by one step inside the agree or disagree half still gives the right direction, and it only shows after one more training event pushes it across the midpoint. For this reason the bench trains a few indices heavily and alternates hint and outcome, so counter errors reach resp_taken within a few cycles. Errors in the handshake show in the cycle they happen, as a wrong req_ready or a response that changes during a stall.

// File: rtl/bhp_pkg.sv
package bhp_pkg;

  // Agreement counter codes; bit 1 set means "hint has been wrong"
  typedef enum logic [1:0] {
    CTR_AGREE_STRONG = 2'd0,
    CTR_AGREE_WEAK   = 2'd1,
    CTR_DIS_WEAK     = 2'd2,
    CTR_DIS_STRONG   = 2'd3
  } agree_ctr_t;

  function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic hint_wrong);
    logic [1:0] nxt;
    nxt = cur;
    if (hint_wrong) begin
      if (cur != CTR_DIS_STRONG) nxt = cur + 2'd1;
    end else begin
      if (cur != CTR_AGREE_STRONG) nxt = cur - 2'd1;
    end
    return nxt;
  endfunction

  function automatic logic ctr_disagrees(input logic [1:0] cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/bhp_index.sv
module bhp_index #(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 6,
  parameter int IDX_LSB = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  // Only the word-address slice selects an entry; the rest is left unused
  logic unused_addr_bits;
  assign unused_addr_bits = ^addr;
  assign idx = addr[IDX_LSB +: IDX_W];
endmodule

// File: rtl/bhp_table.sv
module bhp_table #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_hint_wrong
);
  import bhp_pkg::*;

  logic [ENTRIES-1:0][1:0] ctr_q;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(e));
    always_ff @(posedge clk) begin
      if (rst)      ctr_q[e] <= CTR_AGREE_STRONG;
      else if (hit) ctr_q[e] <= ctr_step(ctr_q[e], wr_hint_wrong);
    end
  end

  // Combinational read sees the registered value, i.e. before any same-cycle write
  assign rd_ctr = ctr_q[rd_idx];
endmodule

// File: rtl/bhp_resp.sv
module bhp_resp (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_taken,
  output logic out_valid,
  input  logic out_ready,
  output logic out_taken
);
  logic valid_q;
  logic taken_q;

  assign in_ready = !valid_q || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      taken_q <= 1'b0;
    end else if (in_valid && in_ready) begin
      valid_q <= 1'b1;
      taken_q <= in_taken;
    end else if (out_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign out_valid = valid_q;
  assign out_taken = taken_q;
endmodule

// File: rtl/hint_override_bpred.sv
module hint_override_bpred #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 64,
  parameter int IDX_LSB = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_hint,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic              resp_taken,
  input  logic              upd_valid,
  output logic              upd_ready,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic              upd_hint,
  input  logic              upd_taken
);
  import bhp_pkg::*;

  localparam int IDX_W = $clog2(ENTRIES);

  logic [IDX_W-1:0] rd_idx;
  logic [IDX_W-1:0] wr_idx;
  logic [1:0]       rd_ctr;
  logic             pred_dir;
  logic             rst_seen_q;

  bhp_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) u_ridx (
    .addr(req_addr), .idx(rd_idx)
  );

  bhp_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) u_widx (
    .addr(upd_addr), .idx(wr_idx)
  );

  bhp_table #(.ENTRIES(ENTRIES)) u_table (
    .clk           (clk),
    .rst           (rst),
    .rd_idx        (rd_idx),
    .rd_ctr        (rd_ctr),
    .wr_en         (upd_valid && upd_ready),
    .wr_idx        (wr_idx),
    .wr_hint_wrong (upd_hint ^ upd_taken)
  );

  // Final direction: static hint flipped when the hint has been losing
  assign pred_dir = req_hint ^ ctr_disagrees(rd_ctr);

  bhp_resp u_resp (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_taken  (pred_dir),
    .out_valid (resp_valid),
    .out_ready (resp_ready),
    .out_taken (resp_taken)
  );

  // Training channel is always open once out of reset
  always_ff @(posedge clk) begin
    if (rst) rst_seen_q <= 1'b0;
    else     rst_seen_q <= 1'b1;
  end
  assign upd_ready = rst_seen_q || !rst;
endmodule

// File: rtl/hint_override_bpred_chk.sv
module hint_override_bpred_chk #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 64,
  parameter int IDX_LSB = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic [ADDR_W-1:0]       req_addr,
  input logic                    req_hint,
  input logic                    resp_valid,
  input logic                    resp_ready,
  input logic                    resp_taken,
  input logic                    upd_valid,
  input logic [ADDR_W-1:0]       upd_addr,
  input logic                    upd_hint,
  input logic                    upd_taken,
  input logic [ENTRIES-1:0][1:0] ctr
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [IDX_W-1:0] ridx;
  logic [IDX_W-1:0] uidx;
  logic             unused_chk_bits;
  assign ridx = req_addr[IDX_LSB +: IDX_W];
  assign uidx = upd_addr[IDX_LSB +: IDX_W];
  assign unused_chk_bits = ^{req_addr, upd_addr};

  // R1
  reset_agree_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ctr == '0));

  // R2
  pred_xor_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (resp_taken == ($past(req_hint) ^ $past(ctr[ridx][1]))));

  // R3
  ctr_up_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && (upd_hint != upd_taken)) |=>
      (ctr[$past(uidx)] == (($past(ctr[uidx]) == 2'd3) ? 2'd3 : ($past(ctr[uidx]) + 2'd1))));

  // R4
  ctr_down_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && (upd_hint == upd_taken)) |=>
      (ctr[$past(uidx)] == (($past(ctr[uidx]) == 2'd0) ? 2'd0 : ($past(ctr[uidx]) - 2'd1))));

  // R7
  resp_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> resp_valid);

  // R7
  resp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_taken)));
endmodule

bind hint_override_bpred hint_override_bpred_chk #(
  .ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .IDX_LSB(IDX_LSB)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_addr   (req_addr),
  .req_hint   (req_hint),
  .resp_valid (resp_valid),
  .resp_ready (resp_ready),
  .resp_taken (resp_taken),
  .upd_valid  (upd_valid),
  .upd_addr   (upd_addr),
  .upd_hint   (upd_hint),
  .upd_taken  (upd_taken),
  .ctr        (u_table.ctr_q)
);

// File: tb/hint_override_bpred_bench.sv
`timescale 1ns/1ps
module hint_override_bpred_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_hint = 1'b0;
  logic        resp_valid;
  logic        resp_ready = 1'b1;
  logic        resp_taken;
  logic        upd_valid = 1'b0;
  logic        upd_ready;
  logic [31:0] upd_addr = '0;
  logic        upd_hint = 1'b0;
  logic        upd_taken = 1'b0;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string phase = "R1 reset";

  // Reference model state
  int ref_ctr [64];
  bit exp_valid = 0;
  bit exp_taken = 0;

  always #2.5 clk = ~clk;

  hint_override_bpred u_hint_override_bpred (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_hint(req_hint),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_taken(resp_taken),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_addr(upd_addr),
    .upd_hint(upd_hint), .upd_taken(upd_taken)
  );

  function automatic int idx_of(input logic [31:0] a);
    return int'((a >> 2) & 32'd63);
  endfunction

  always @(posedge clk) begin
    bit acc;
    if (rst) begin
      foreach (ref_ctr[i]) ref_ctr[i] = 0;
      exp_valid = 0;
      exp_taken = 0;
    end else begin
      acc = req_valid && (!exp_valid || resp_ready);
      if (acc) begin
        exp_valid = 1;
        exp_taken = req_hint ^ (ref_ctr[idx_of(req_addr)] >= 2);
      end else if (resp_ready) begin
        exp_valid = 0;
      end
      if (upd_valid) begin
        if (upd_hint != upd_taken) begin
          if (ref_ctr[idx_of(upd_addr)] < 3) ref_ctr[idx_of(upd_addr)]++;
        end else begin
          if (ref_ctr[idx_of(upd_addr)] > 0) ref_ctr[idx_of(upd_addr)]--;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check(resp_valid == exp_valid, {phase, " R7 resp_valid"}, resp_valid, exp_valid);
      if (exp_valid)
        check(resp_taken == exp_taken, {phase, " R2 resp_taken"}, resp_taken, exp_taken);
      if (!rst) begin
        check(req_ready == (!exp_valid || resp_ready), "R8 req_ready", req_ready,
              int'(!exp_valid || resp_ready));
        check(upd_ready == 1'b1, "R9 upd_ready", upd_ready, 1);
      end
    end
  end

  task automatic cyc(input bit rv, input logic [31:0] ra, input bit rh, input bit rr,
                     input bit uv, input logic [31:0] ua, input bit uh, input bit ut);
    @(negedge clk); #1;
    req_valid = rv; req_addr = ra; req_hint = rh; resp_ready = rr;
    upd_valid = uv; upd_addr = ua; upd_hint = uh; upd_taken = ut;
  endtask

  task automatic idle();
    cyc(0, 32'h0, 0, 1, 0, 32'h0, 0, 0);
  endtask

  localparam logic [31:0] A = 32'h0000_0124;

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;

    phase = "R1 untrained";
    for (int i = 0; i < 64; i++) cyc(1, 32'(i) << 2, i[0], 1, 0, 0, 0, 0);
    idle();

    phase = "R3 hint wrong";
    for (int k = 0; k < 5; k++) begin
      cyc(0, 0, 0, 1, 1, A, 1, 0);
      cyc(1, A, 1, 1, 0, 0, 0, 0);
      cyc(1, A, 0, 1, 0, 0, 0, 0);
    end

    phase = "R4 hint right";
    for (int k = 0; k < 5; k++) begin
      cyc(0, 0, 0, 1, 1, A, 0, 0);
      cyc(1, A, 1, 1, 0, 0, 0, 0);
    end

    phase = "R5 alias";
    cyc(0, 0, 0, 1, 1, A + 32'h100, 1, 0);
    cyc(0, 0, 0, 1, 1, A | 32'hF000_0003, 0, 1);
    cyc(1, A, 1, 1, 0, 0, 0, 0);
    cyc(1, A + 32'h4, 1, 1, 0, 0, 0, 0);

    phase = "R6 same cycle";
    cyc(1, A, 1, 1, 1, A, 1, 1);
    cyc(1, A, 1, 1, 1, A, 1, 1);
    cyc(1, A, 1, 1, 1, A, 1, 0);
    cyc(1, A, 1, 1, 1, A, 1, 0);
    cyc(1, A, 1, 1, 0, 0, 0, 0);

    phase = "R9 ignored";
    for (int k = 0; k < 4; k++) cyc(0, 0, 0, 1, 0, A, 1, 0);
    cyc(1, A, 0, 1, 0, 0, 0, 0);

    phase = "R7 stall";
    cyc(1, A, 1, 0, 0, 0, 0, 0);
    cyc(1, A + 32'h8, 0, 0, 0, 0, 0, 0);
    cyc(1, A + 32'h8, 0, 0, 1, A, 0, 1);
    cyc(1, A + 32'h8, 0, 1, 0, 0, 0, 0);
    cyc(1, A, 1, 1, 0, 0, 0, 0);

    phase = "R2 mixed";
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] ra;
      logic [31:0] ua;
      ra = ($urandom & 32'hFFFF_FF03) | ((32'($urandom % 6)) << 2);
      ua = ($urandom & 32'hFFFF_FF03) | ((32'($urandom % 6)) << 2);
      cyc($urandom % 4 != 0, ra, $urandom % 2 == 0, $urandom % 4 != 0,
          $urandom % 2 == 0, ua, $urandom % 2 == 0, $urandom % 3 == 0);
    end
    idle();
    idle();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule